// File: doc/BRIEF.md
# Half-Step Fractional Clock Divider

This block produces a slower memory clock from the core clock. The divide ratio runs from 2 to 5 in steps of one half. It is chosen by a 3-bit ratio code and a start bit, both held in a control register elsewhere in the chip. The output clock is a registered level that toggles on core clock edges. Integer ratios give periods of a fixed length. Half-integer ratios alternate a short period with a long one, so that every pair of output periods spans exactly twice the ratio in core cycles.

A new ratio is accepted only when the start bit rises. Ratio-code changes made while the start bit is held steady are ignored. When the divider is stopped, the first rising edge launches the clock with a high phase. When it is already running, the new ratio waits until the current output period has ended, so no phase is ever cut short. A reserved code presented at a start edge leaves the old ratio in place and raises an error flag. The next start edge with a valid code clears that flag.

Top module: `halfstep_clkdiv`

## Requirements
- R1: The ratio code sets a half-step count H = code + 3. Code 1 divides by 2, 2 by 2.5, 3 by 3, 4 by 3.5, 5 by 4, 6 by 4.5 and 7 by 5. Any two consecutive output periods together span exactly H core cycles.
- R2: An output period of P core cycles is high for ceil(P/2) cycles and then low for floor(P/2) cycles. For odd H the periods alternate floor(H/2) and ceil(H/2), and the shorter one comes first after every launch or ratio load.
- R3: After reset the divider is stopped, `div_clk_o`, `running_o` and `cfg_err_o` are 0, and the ratio in force is code 3 (divide by 3, H = 6).
- R4: A start edge is a cycle in which `start_i` is 1 and was 0 in the previous cycle. The previous value counts as 1 during reset, so a start bit held high through reset does not launch. A start edge while stopped raises `running_o` and `div_clk_o` in the next cycle, and the first period uses the new ratio.
- R5: A change of `ratio_code_i` without a start edge has no effect on the output. Holding `start_i` at 1 never retriggers. The code is captured only in the cycle of the edge.
- R6: A valid start edge while running takes effect only after the current output period ends with its low phase. The next period begins with the new ratio and its shorter slot, and no phase is shortened.
- R7: A start edge with the reserved code 0 leaves the ratio in force unchanged and sets `cfg_err_o`. If the divider was stopped, it launches with the ratio in force. A start edge with a valid code clears `cfg_err_o`.
- R8: While stopped, `div_clk_o` is held low. Once running, `running_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code_i | input | 3 | Ratio code (0 reserved, 1..7 = divide by 2..5 in half steps) |
| start_i | input | 1 | Start bit; a rising edge launches or reloads |
| div_clk_o | output | 1 | Divided clock |
| running_o | output | 1 | Divider is running |
| cfg_err_o | output | 1 | Last start edge carried the reserved code |

## Verification
The hardest case to reach is a start edge that arrives while the divider is mid-period. Here the pending ratio must wait for the period boundary and then restart the short/long alternation. To reach it, the bench launches each old ratio and drops the start bit while scrambling the code. It then raises the start bit on the first cycle of the second (long) period, and changes the code again while the bit is still held high. This is swept over every old and new code, including the reserved one. The whole output stream is compared sample by sample against a pattern built arithmetically from the two half-step counts and the switch period.

// File: rtl/halfstep_pkg.sv
package halfstep_pkg;

    localparam int unsigned CODE_W    = 3;
    localparam int unsigned HALF_OFS  = 3;
    localparam int unsigned MAX_HALF  = (1 << CODE_W) - 1 + HALF_OFS;
    localparam int unsigned HALF_W    = $clog2(MAX_HALF + 1);
    localparam int unsigned MAX_PHASE = (MAX_HALF + 3) / 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HALF_W-1:0] half_t;

    localparam code_t CODE_RSVD = '0;
    localparam code_t CODE_DFLT = code_t'(3);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    // phase state of the generator: level, period slot, cycles left in phase
    typedef struct packed {
        logic  hi;
        logic  odd_slot;
        half_t left;
    } phase_t;

    function automatic half_t half_of(input code_t code);
        return half_t'(code) + half_t'(HALF_OFS);
    endfunction

    // length of one output period: short slot, or long slot for odd half counts
    function automatic half_t period_len(input half_t h, input logic slot);
        return (h >> 1) + half_t'(h[0] & slot);
    endfunction

    function automatic half_t hi_len(input half_t p);
        return (p + half_t'(1)) >> 1;
    endfunction

    function automatic half_t lo_len(input half_t p);
        return p >> 1;
    endfunction

endpackage

// File: rtl/hs_start_edge.sv
module hs_start_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    // previous level resets to 1 so a bit held high through reset is no edge
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/hs_ratio_cfg.sv
module hs_ratio_cfg
    import halfstep_pkg::*;
#(
    parameter code_t RESET_CODE = CODE_DFLT
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t code_i,
    input  logic  rise_i,
    input  logic  run_i,
    input  logic  bound_i,
    output half_t act_half_o,
    output half_t next_half_o,
    output logic  restart_o,
    output logic  err_o
);
    localparam half_t RESET_HALF = half_of(RESET_CODE);

    half_t act_q;
    half_t pend_half_q;
    logic  pend_q;
    logic  err_q;

    logic  code_ok;
    logic  launch;
    logic  apply;

    always_comb begin
        code_ok = (code_i != CODE_RSVD);
        launch  = rise_i & ~run_i;
        apply   = run_i & bound_i & pend_q;
        if (launch)
            next_half_o = code_ok ? half_of(code_i) : act_q;
        else if (apply)
            next_half_o = pend_half_q;
        else
            next_half_o = act_q;
        restart_o = launch | apply;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q       <= RESET_HALF;
            pend_half_q <= RESET_HALF;
            pend_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (restart_o) act_q <= next_half_o;
            if (apply)     pend_q <= 1'b0;
            // a fresh request overrides the one being consumed this cycle
            if (rise_i && run_i && code_ok) begin
                pend_q      <= 1'b1;
                pend_half_q <= half_of(code_i);
            end
            if (rise_i) err_q <= ~code_ok;
        end
    end

    assign act_half_o = act_q;
    assign err_o      = err_q;
endmodule

// File: rtl/hs_phase_gen.sv
module hs_phase_gen
    import halfstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_i,
    input  logic  restart_i,
    input  half_t next_half_i,
    input  half_t act_half_i,
    output logic  clk_o,
    output logic  run_o,
    output logic  bound_o
);
    run_e   st_q;
    phase_t ph_q;
    logic   slot_n;

    assign bound_o = (st_q == ST_RUN) & ~ph_q.hi & (ph_q.left == '0);
    assign slot_n  = restart_i ? 1'b0 : ~ph_q.odd_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            ph_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (rise_i) begin
                        st_q          <= ST_RUN;
                        ph_q.hi       <= 1'b1;
                        ph_q.odd_slot <= 1'b0;
                        ph_q.left     <= hi_len(period_len(next_half_i, 1'b0)) - half_t'(1);
                    end
                end
                ST_RUN: begin
                    if (ph_q.left != '0) begin
                        ph_q.left <= ph_q.left - half_t'(1);
                    end else if (ph_q.hi) begin
                        ph_q.hi   <= 1'b0;
                        ph_q.left <= lo_len(period_len(act_half_i, ph_q.odd_slot)) - half_t'(1);
                    end else begin
                        ph_q.hi       <= 1'b1;
                        ph_q.odd_slot <= slot_n;
                        ph_q.left     <= hi_len(period_len(next_half_i, slot_n)) - half_t'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign clk_o = ph_q.hi;
    assign run_o = (st_q == ST_RUN);
endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv
    import halfstep_pkg::*;
#(
    parameter code_t RESET_CODE = CODE_DFLT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ratio_code_i,
    input  logic       start_i,
    output logic       div_clk_o,
    output logic       running_o,
    output logic       cfg_err_o
);
    logic  rise;
    logic  run;
    logic  bound;
    logic  restart;
    half_t act_half;
    half_t next_half;

    hs_start_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (start_i),
        .rise_o (rise)
    );

    hs_ratio_cfg #(.RESET_CODE(RESET_CODE)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .code_i      (code_t'(ratio_code_i)),
        .rise_i      (rise),
        .run_i       (run),
        .bound_i     (bound),
        .act_half_o  (act_half),
        .next_half_o (next_half),
        .restart_o   (restart),
        .err_o       (cfg_err_o)
    );

    hs_phase_gen u_phase (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (rise),
        .restart_i   (restart),
        .next_half_i (next_half),
        .act_half_i  (act_half),
        .clk_o       (div_clk_o),
        .run_o       (run),
        .bound_o     (bound)
    );

    assign running_o = run;
endmodule

// File: rtl/halfstep_clkdiv_chk.sv
module halfstep_clkdiv_chk
    import halfstep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] ratio_code_i,
    input logic       start_i,
    input logic       div_clk_o,
    input logic       running_o,
    input logic       cfg_err_o
);
    logic       prev_q;
    logic       seen_hi_q;
    logic [7:0] run_len_q;
    logic [7:0] last_hi_q;

    // run_len_q: length of the current level run up to the previous cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b0;
            seen_hi_q <= 1'b0;
            run_len_q <= 8'd0;
            last_hi_q <= 8'd0;
        end else begin
            prev_q <= div_clk_o;
            if (div_clk_o != prev_q) begin
                run_len_q <= 8'd1;
                if (prev_q) begin
                    last_hi_q <= run_len_q;
                    seen_hi_q <= 1'b1;
                end
            end else if (run_len_q != 8'hFF) begin
                run_len_q <= run_len_q + 8'd1;
            end
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !running_o |-> !div_clk_o); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        running_o |=> running_o); // R8

    AST_LAUNCH_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(running_o) |-> (div_clk_o && $past(start_i))); // R4

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err_o) |-> ($past(start_i) && ($past(ratio_code_i) == 3'd0))); // R7

    AST_PERIOD_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (running_o && $past(running_o) && div_clk_o && !prev_q && seen_hi_q)
        |-> (last_hi_q == run_len_q || last_hi_q == run_len_q + 8'd1)); // R2

    AST_PHASE_MAX: assert property (@(posedge clk) disable iff (rst)
        (running_o && $past(running_o)) |-> (run_len_q <= 8'(MAX_PHASE))); // R6
endmodule

bind halfstep_clkdiv halfstep_clkdiv_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ratio_code_i (ratio_code_i),
    .start_i      (start_i),
    .div_clk_o    (div_clk_o),
    .running_o    (running_o),
    .cfg_err_o    (cfg_err_o)
);

// File: tb/tb_halfstep_clkdiv.sv
`timescale 1ns/1ps
module tb_halfstep_clkdiv;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] code = 3'd3;
    logic       div_clk;
    logic       running;
    logic       cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    halfstep_clkdiv dut (
        .clk          (clk),
        .rst          (rst),
        .ratio_code_i (code),
        .start_i      (start),
        .div_clk_o    (div_clk),
        .running_o    (running),
        .cfg_err_o    (cfg_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // expected output level at sample idx: half count ha for sw periods, then hb
    function automatic int exp_lvl(input int ha, input int hb, input int sw, input int idx);
        int t = 0;
        for (int p = 0; p < 4000; p++) begin
            int h    = (p < sw) ? ha : hb;
            int q    = (p < sw) ? p : p - sw;
            int plen = h / 2 + (((h % 2) == 1 && (q % 2) == 1) ? 1 : 0);
            int hi   = (plen + 1) / 2;
            if (idx < t + hi)   return 1;
            if (idx < t + plen) return 0;
            t += plen;
        end
        return -1;
    endfunction

    task automatic do_reset(input logic st_lvl);
        @(negedge clk);
        rst   = 1'b1;
        start = st_lvl;
        code  = 3'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // start low for one edge, then high; first sample follows at next negedge
    task automatic launch(input logic [2:0] c);
        code  = c;
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
    endtask

    task automatic capture(input int half, input int n, input string tag);
        int bad = 0;
        int bi = 0;
        int ba = 0;
        int be = 0;
        for (int i = 0; i < n; i++) begin
            int e;
            @(negedge clk);
            e = exp_lvl(half, half, 100000, i);
            if (div_clk !== e[0] || running !== 1'b1) begin
                if (bad == 0) begin bi = i; ba = int'(div_clk); be = e; end
                bad++;
            end
        end
        check(bad == 0, tag, $sformatf("half=%0d stream, first bad sample %0d", half, bi), ba, be);
    endtask

    task automatic run_change(input int a, input int b);
        int ha = a + 3;
        int hb = (b == 0) ? ha : b + 3;
        int sw = (b == 0) ? 100000 : 2;
        int s  = ha / 2;
        int n  = ha + 3 * hb;
        int bad = 0;
        int bi = 0;
        int ba = 0;
        int be = 0;
        string tag;
        tag = (b == 0) ? "R7" : "R6";
        do_reset(1'b0);
        launch(3'(a));
        for (int i = 0; i < n; i++) begin
            int e;
            @(negedge clk);
            e = exp_lvl(ha, hb, sw, i);
            if (div_clk !== e[0] || running !== 1'b1) begin
                if (bad == 0) begin bi = i; ba = int'(div_clk); be = e; end
                bad++;
            end
            if (i == 1) begin start = 1'b0; code = ~3'(a); end
            if (i == s) begin code = 3'(b); start = 1'b1; end
            if (i == s + 1) code = 3'(b) ^ 3'b101;
        end
        check(bad == 0, tag, $sformatf("R5 switch %0d->%0d stream, first bad sample %0d", a, b, bi), ba, be);
        check(cfg_err === (b == 0), "R7", $sformatf("error flag after switch %0d->%0d", a, b),
              int'(cfg_err), (b == 0) ? 1 : 0);
    endtask

    initial begin
        int bad;
        // R3: reset state
        do_reset(1'b0);
        check(div_clk === 1'b0, "R3", "div_clk after reset", int'(div_clk), 0);
        check(running === 1'b0, "R3", "running after reset", int'(running), 0);
        check(cfg_err === 1'b0, "R3", "cfg_err after reset", int'(cfg_err), 0);

        // R8 / R5: code changes while stopped with start low
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            code = 3'(i);
            @(negedge clk);
            if (div_clk !== 1'b0 || running !== 1'b0) bad++;
        end
        check(bad == 0, "R8", "stopped output stays low under code changes", bad, 0);

        // R4: start held high through reset does not launch
        do_reset(1'b1);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (running !== 1'b0 || div_clk !== 1'b0) bad++;
        end
        check(bad == 0, "R4", "held start after reset, cycles running", bad, 0);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(running === 1'b1 && div_clk === 1'b1, "R4", "launch after 0->1",
              int'({running, div_clk}), 3);

        // R3 / R7: reserved code at launch runs with default divide by 3
        do_reset(1'b0);
        launch(3'd0);
        capture(6, 24, "R3");
        check(cfg_err === 1'b1, "R7", "error flag after reserved launch", int'(cfg_err), 1);

        // R1 / R2: every valid code from a fresh launch
        for (int c = 1; c < 8; c++) begin
            do_reset(1'b0);
            launch(3'(c));
            capture(c + 3, 4 * (c + 3), "R1");
            check(cfg_err === 1'b0, "R2", $sformatf("no error for code %0d", c), int'(cfg_err), 0);
        end

        // R6 / R7 / R5: every old code against every new code
        for (int a = 1; a < 8; a++)
            for (int b = 0; b < 8; b++)
                run_change(a, b);

        // R7: reserved edge sets the flag, next valid edge clears it
        do_reset(1'b0);
        launch(3'd2);
        repeat (5) @(negedge clk);
        code  = 3'd0;
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(cfg_err === 1'b1, "R7", "flag set by reserved edge", int'(cfg_err), 1);
        start = 1'b0;
        @(negedge clk);
        code  = 3'd5;
        start = 1'b1;
        @(negedge clk);
        check(cfg_err === 1'b0, "R7", "flag cleared by valid edge", int'(cfg_err), 0);
        check(running === 1'b1, "R8", "still running after reloads", int'(running), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule